// File: doc/BRIEF.md
# Clocked Serial Link Bit Engine

This block is the bit-level engine of a single-master, two-wire clocked serial link. It owns the link clock output, the data line (an output value, an output enable and an input), and a direction signal for an external level translator. A controlling block issues one command at a time through a valid/ready handshake. A command either shifts out a left-aligned frame after a start bit, emits a run of idle clocks, samples a number of incoming bits, or runs a link-break sequence. Frame contents, CRC and protocol decisions are made elsewhere.

Every logical bit is inverted on the wire, so a logical 1 is a low line. Each bit period first drives the link clock low for `HALF` system clocks and then drives it high. Outgoing data changes when the clock falls. Incoming data passes a two-flop synchronizer and is sampled on the last system cycle of the low phase. The break sequence uses lengths set by parameters for the pre-break high run, the break low run and the post-break high run. The echo-delay idle run inside the break takes its length from the command's count field. When a command finishes, a one-cycle `done` pulse is raised, and after a receive the received bits are available right-aligned.

Top module: `sclk_link_engine`

## Requirements
- R1: After reset the link clock is high, the data output is 1 (line high, logical zero), the output enable and translator direction are both 1, `cmd_ready` is 1 and `done` is 0. While the engine is idle the link clock stays high.
- R2: A send command (`cmd_op`=0) with count N from 1 to FRAME_W gives N+1 clock periods. The first carries a start bit of logical 1. The rest carry `cmd_frame` bits from index FRAME_W-1 downward. Each bit is driven inverted on the data output with output enable and direction at 1.
- R3: A send with count 0 or count above FRAME_W, or a receive with count above FRAME_W, gives no link clock edge. `done` and `reject` are raised together on the accepting cycle. `reject` is never 1 without `done`.
- R4: An idle command (`cmd_op`=1) with count N gives exactly N clock periods with the data output at 1 (logical zero) and the output enabled. N=0 gives `done` with no clock.
- R5: A receive command (`cmd_op`=2) with count N gives N clock periods with output enable and direction at 0. Each sampled line level is inverted. At `done`, `rx_data` holds the bits right-aligned, with the first received bit at index N-1 and zeros above.
- R6: A break command (`cmd_op`=3) with count E gives PRE_CLKS periods at logical 0, then BRK_CLKS periods at logical 1, then E periods at logical 0, then POST_CLKS periods at logical 0. All of these are driven.
- R7: The output enable is never 1 while the direction signal is 0. When the line is turned back to output, direction rises at least one cycle before output enable.
- R8: `cmd_ready` is 0 from the cycle after a command is accepted until its `done`. Each accepted command gives exactly one `done`, raised as the engine returns to idle.
- R9: Within every bit period the link clock stays low for exactly HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | 0 send, 1 idle clocks, 2 receive, 3 break |
| cmd_frame | input | FRAME_W | Left-aligned transmit frame |
| cmd_count | input | CNT_W | Bit count, idle count, or echo count for break |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | Command refused, valid with done |
| rx_data | output | FRAME_W | Received bits, right-aligned |
| link_clk | output | 1 | Link clock |
| link_dout | output | 1 | Data line output level |
| link_oe | output | 1 | Data line output enable |
| link_dir | output | 1 | Level-translator direction, 1 toward link |
| link_din | input | 1 | Data line input level |

## Verification
A wrong segment or remaining-count register shows up within one bit period as an extra, missing or mis-valued clock period in the stream the scoreboard expects. It is reported at the rising edge where it occurs, or at the following `done`. A wrong shift-register state shows up either on the very next transmitted bit or in `rx_data` at `done`. Direction and enable ordering faults are visible in the single cycle where the line changes direction. A miscounted half-period is reported at the first clock rise.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    OP_SEND  = 2'd0,
    OP_IDLE  = 2'd1,
    OP_RECV  = 2'd2,
    OP_BREAK = 2'd3
  } lnk_op_e;

  typedef enum logic [2:0] {
    SG_START,
    SG_TX,
    SG_ZERO,
    SG_RX,
    SG_PRE,
    SG_BRK,
    SG_ECHO,
    SG_POST
  } lnk_seg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEG,
    ST_LOW,
    ST_HIGH
  } lnk_st_e;
endpackage

// File: rtl/lnk_halfcnt.sv
module lnk_halfcnt #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lnk_sync.sv
module lnk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/lnk_shift.sv
module lnk_shift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_tx,
  input  logic [W-1:0] frame,
  input  logic         shift_tx,
  input  logic         clr_rx,
  input  logic         shift_rx,
  input  logic         rx_bit,
  output logic         tx_msb,
  output logic [W-1:0] rx_val
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst)           tx_q <= '0;
    else if (load_tx)  tx_q <= frame;
    else if (shift_tx) tx_q <= {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || clr_rx) rx_q <= '0;
    else if (shift_rx) rx_q <= {rx_q[W-2:0], rx_bit};
  end

  assign tx_msb = tx_q[W-1];
  assign rx_val = rx_q;
endmodule

// File: rtl/lnk_seq.sv
module lnk_seq
  import lnk_pkg::*;
#(
  parameter int FRAME_W   = 64,
  parameter int CNT_W     = 8,
  parameter int PRE_CLKS  = 50,
  parameter int BRK_CLKS  = 256,
  parameter int POST_CLKS = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  lnk_op_e          cmd_op,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             half_last,
  input  logic             tx_msb,
  input  logic             rx_line,
  output logic             cmd_ready,
  output logic             half_run,
  output logic             load_tx,
  output logic             shift_tx,
  output logic             clr_rx,
  output logic             shift_rx,
  output logic             rx_bit,
  output logic             done,
  output logic             reject,
  output logic             lclk,
  output logic             dout,
  output logic             oe,
  output logic             dir
);
  localparam int REM_W = 16;

  lnk_st_e          st_q;
  lnk_seg_e         seg_q;
  logic [REM_W-1:0] rem_q;
  logic [CNT_W-1:0] arg_q;
  logic             want_out;
  logic             bit_val;
  logic             accept;
  logic             send_bad;
  logic             recv_bad;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign send_bad  = (cmd_count == '0) || (int'(cmd_count) > FRAME_W);
  assign recv_bad  = int'(cmd_count) > FRAME_W;
  assign want_out  = (seg_q != SG_RX);
  assign half_run  = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign load_tx   = accept && (cmd_op == OP_SEND);
  assign clr_rx    = accept && (cmd_op == OP_RECV) && !recv_bad;
  assign shift_tx  = (st_q == ST_HIGH) && half_last && (seg_q == SG_TX);
  assign shift_rx  = (st_q == ST_LOW) && half_last && (seg_q == SG_RX);
  assign rx_bit    = ~rx_line;

  always_comb begin
    case (seg_q)
      SG_START: bit_val = 1'b1;
      SG_TX:    bit_val = tx_msb;
      SG_BRK:   bit_val = 1'b1;
      default:  bit_val = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      seg_q  <= SG_ZERO;
      rem_q  <= '0;
      arg_q  <= '0;
      lclk   <= 1'b1;
      dout   <= 1'b1;
      oe     <= 1'b1;
      dir    <= 1'b1;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            arg_q <= cmd_count;
            case (cmd_op)
              OP_SEND: begin
                if (send_bad) begin
                  done   <= 1'b1;
                  reject <= 1'b1;
                end else begin
                  seg_q <= SG_START;
                  rem_q <= REM_W'(1);
                  st_q  <= ST_SEG;
                end
              end
              OP_IDLE: begin
                seg_q <= SG_ZERO;
                rem_q <= REM_W'(cmd_count);
                st_q  <= ST_SEG;
              end
              OP_RECV: begin
                if (recv_bad) begin
                  done   <= 1'b1;
                  reject <= 1'b1;
                end else begin
                  seg_q <= SG_RX;
                  rem_q <= REM_W'(cmd_count);
                  st_q  <= ST_SEG;
                end
              end
              default: begin
                seg_q <= SG_PRE;
                rem_q <= REM_W'(PRE_CLKS);
                st_q  <= ST_SEG;
              end
            endcase
          end
        end
        ST_SEG: begin
          if (rem_q == '0) begin
            case (seg_q)
              SG_START: begin seg_q <= SG_TX;   rem_q <= REM_W'(arg_q);     end
              SG_PRE:   begin seg_q <= SG_BRK;  rem_q <= REM_W'(BRK_CLKS);  end
              SG_BRK:   begin seg_q <= SG_ECHO; rem_q <= REM_W'(arg_q);     end
              SG_ECHO:  begin seg_q <= SG_POST; rem_q <= REM_W'(POST_CLKS); end
              default: begin
                st_q <= ST_IDLE;
                done <= 1'b1;
              end
            endcase
          end else if (want_out && !dir) begin
            dir <= 1'b1;
          end else if (want_out && !oe) begin
            oe <= 1'b1;
          end else if (!want_out && (oe || dir)) begin
            oe  <= 1'b0;
            dir <= 1'b0;
          end else begin
            lclk <= 1'b0;
            if (want_out) dout <= ~bit_val;
            st_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (half_last) begin
            lclk <= 1'b1;
            st_q <= ST_HIGH;
          end
        end
        default: begin
          if (half_last) begin
            rem_q <= rem_q - 1'b1;
            st_q  <= ST_SEG;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sclk_link_engine.sv
module sclk_link_engine
  import lnk_pkg::*;
#(
  parameter int FRAME_W   = 64,
  parameter int CNT_W     = 8,
  parameter int HALF      = 4,
  parameter int SYNC_STG  = 2,
  parameter int PRE_CLKS  = 50,
  parameter int BRK_CLKS  = 256,
  parameter int POST_CLKS = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [FRAME_W-1:0] cmd_frame,
  input  logic [CNT_W-1:0]   cmd_count,
  output logic               done,
  output logic               reject,
  output logic [FRAME_W-1:0] rx_data,
  output logic               link_clk,
  output logic               link_dout,
  output logic               link_oe,
  output logic               link_dir,
  input  logic               link_din
);
  logic half_run, half_last;
  logic load_tx, shift_tx, clr_rx, shift_rx, rx_bit, tx_msb;
  logic din_s;

  lnk_halfcnt #(.HALF(HALF)) u_half (
    .clk(clk), .rst(rst), .run(half_run), .last(half_last)
  );

  lnk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(link_din), .q(din_s)
  );

  lnk_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load_tx(load_tx), .frame(cmd_frame),
    .shift_tx(shift_tx), .clr_rx(clr_rx), .shift_rx(shift_rx),
    .rx_bit(rx_bit), .tx_msb(tx_msb), .rx_val(rx_data)
  );

  lnk_seq #(
    .FRAME_W(FRAME_W), .CNT_W(CNT_W), .PRE_CLKS(PRE_CLKS),
    .BRK_CLKS(BRK_CLKS), .POST_CLKS(POST_CLKS)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(lnk_op_e'(cmd_op)),
    .cmd_count(cmd_count), .half_last(half_last), .tx_msb(tx_msb),
    .rx_line(din_s), .cmd_ready(cmd_ready), .half_run(half_run),
    .load_tx(load_tx), .shift_tx(shift_tx), .clr_rx(clr_rx),
    .shift_rx(shift_rx), .rx_bit(rx_bit), .done(done), .reject(reject),
    .lclk(link_clk), .dout(link_dout), .oe(link_oe), .dir(link_dir)
  );
endmodule

// File: rtl/sclk_link_engine_chk.sv
module sclk_link_engine_chk (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic done,
  input logic reject,
  input logic link_clk,
  input logic link_oe,
  input logic link_dir
);
  a_r7_drive_needs_dir: assert property (@(posedge clk) disable iff (rst)
    link_oe |-> link_dir);

  a_r7_dir_before_drive: assert property (@(posedge clk) disable iff (rst)
    $rose(link_oe) |-> $past(link_dir));

  a_r8_done_at_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  a_r1_idle_clk_high: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> link_clk);

  a_r3_reject_with_done: assert property (@(posedge clk) disable iff (rst)
    reject |-> done);

  a_r9_low_holds: assert property (@(posedge clk) disable iff (rst)
    $fell(link_clk) |=> !link_clk);
endmodule

bind sclk_link_engine sclk_link_engine_chk u_chk (.*);

// File: tb/sclk_link_engine_tb_top.sv
module sclk_link_engine_tb_top;
  localparam int FW   = 64;
  localparam int CW   = 8;
  localparam int HALF = 4;
  localparam int PRE  = 6;
  localparam int BRK  = 12;
  localparam int POST = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [FW-1:0] cmd_frame = '0;
  logic [CW-1:0] cmd_count = '0;
  logic          done, reject;
  logic [FW-1:0] rx_data;
  logic          link_clk, link_dout, link_oe, link_dir;
  logic          link_din;

  sclk_link_engine #(
    .FRAME_W(FW), .CNT_W(CW), .HALF(HALF), .SYNC_STG(2),
    .PRE_CLKS(PRE), .BRK_CLKS(BRK), .POST_CLKS(POST)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_frame(cmd_frame), .cmd_count(cmd_count),
    .done(done), .reject(reject), .rx_data(rx_data), .link_clk(link_clk),
    .link_dout(link_dout), .link_oe(link_oe), .link_dir(link_dir),
    .link_din(link_din)
  );

  typedef struct {
    bit    drv;
    bit    val;
    string req;
  } exp_t;

  exp_t    expq[$];
  int      checks = 0;
  int      errors = 0;
  int      rises = 0;
  int      low_cnt = 0;
  logic    prev_lclk = 1'b1;
  logic [FW-1:0] rx_vec = '0;
  int      rx_n = 0;
  int      rx_idx = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model: presents the next inverted receive bit after each rise
  assign link_din = (rx_idx < rx_n) ? ~rx_vec[rx_n-1-rx_idx] : 1'b1;
  always @(posedge link_clk) begin
    if (!link_oe && rx_idx < rx_n) rx_idx = rx_idx + 1;
  end

  // monitor: scoreboard pop on each link clock rise, sampled at negedge
  always @(negedge clk) begin
    if (!rst) begin
      if (!link_clk) low_cnt++;
      if (!prev_lclk && link_clk) begin
        rises++;
        chk(low_cnt == HALF, "R9", "low phase length", low_cnt, HALF);
        if (expq.size() == 0) begin
          chk(1'b0, "R8", "unexpected link clock", rises, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.drv)
            chk(link_oe && link_dir && (~link_dout == e.val), e.req,
                "driven bit {oe,dir,bit}", {link_oe, link_dir, ~link_dout},
                {2'b11, e.val});
          else
            chk(!link_oe && !link_dir, e.req, "released line {oe,dir}",
                {link_oe, link_dir}, 0);
        end
        low_cnt = 0;
      end
      prev_lclk = link_clk;
    end
  end

  task automatic push(input bit drv, input bit val, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.drv = drv; e.val = val; e.req = req;
      expq.push_back(e);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [FW-1:0] frame,
                         input int count, input bit exp_rej,
                         input bit check_rx, input logic [FW-1:0] exp_rx,
                         input string req);
    int r0;
    while (!cmd_ready) @(negedge clk);
    r0 = rises;
    cmd_op = op; cmd_frame = frame; cmd_count = CW'(count); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!exp_rej)
      chk(!cmd_ready, "R8", "ready low while busy", cmd_ready, 0);
    while (!done) @(negedge clk);
    chk(reject == exp_rej, exp_rej ? "R3" : "R8", "reject flag", reject, exp_rej);
    if (exp_rej)
      chk(rises == r0, "R3", "no clocks on reject", rises - r0, 0);
    chk(expq.size() == 0, req, "clock periods left unmatched", expq.size(), 0);
    expq.delete();
    if (check_rx)
      chk(rx_data == exp_rx, "R5", "received data", rx_data, exp_rx);
    @(negedge clk);
    chk(!done, "R8", "done is one pulse", done, 0);
  endtask

  task automatic do_send(input logic [FW-1:0] frame, input int n);
    push(1, 1, "R2", 1);
    for (int i = 0; i < n; i++) push(1, frame[FW-1-i], "R2", 1);
    run_cmd(2'd0, frame, n, 0, 0, '0, "R2");
  endtask

  task automatic do_recv(input logic [FW-1:0] v, input int n);
    rx_vec = v; rx_n = n; rx_idx = 0;
    push(0, 0, "R5", n);
    run_cmd(2'd2, '0, n, 0, 1, v, "R5");
    rx_n = 0; rx_idx = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(link_clk == 1'b1, "R1", "link clock after reset", link_clk, 1);
    chk(link_dout == 1'b1, "R1", "data output after reset", link_dout, 1);
    chk(link_oe && link_dir, "R1", "oe/dir after reset", {link_oe, link_dir}, 3);
    chk(cmd_ready && !done, "R1", "ready/done after reset", {cmd_ready, done}, 2);

    // R2 sends
    do_send({8'hA5, 56'h0}, 8);
    do_send(64'hF0E1_D2C3_B4A5_9687, 64);
    do_send(64'h0, 1);
    do_send({3'b101, 61'h0}, 3);

    // R3 rejects
    run_cmd(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, '0, "R3");
    run_cmd(2'd0, 64'h1234, 65, 1, 0, '0, "R3");
    run_cmd(2'd2, '0, 70, 1, 0, '0, "R3");

    // R4 idle runs
    push(1, 0, "R4", 5);
    run_cmd(2'd1, '0, 5, 0, 0, '0, "R4");
    run_cmd(2'd1, '0, 0, 0, 0, '0, "R4");

    // R5 receives, R7 direction afterwards
    do_recv(64'hB3C, 12);
    chk(!link_oe && !link_dir, "R7", "line released after receive",
        {link_oe, link_dir}, 0);
    do_recv(64'h8000_0000_0000_0001, 64);
    do_recv(64'h1, 1);
    do_send({2'b01, 62'h0}, 2);
    chk(link_oe && link_dir, "R7", "line driven after send", {link_oe, link_dir}, 3);

    // R6 break with echo run of 3, then of 0
    push(1, 0, "R6", PRE); push(1, 1, "R6", BRK);
    push(1, 0, "R6", 3);   push(1, 0, "R6", POST);
    run_cmd(2'd3, '0, 3, 0, 0, '0, "R6");
    push(1, 0, "R6", PRE); push(1, 1, "R6", BRK); push(1, 0, "R6", POST);
    run_cmd(2'd3, '0, 0, 0, 0, '0, "R6");

    // R1 idle level after activity
    repeat (3) @(negedge clk);
    chk(link_clk && cmd_ready, "R1", "idle clock high", {link_clk, cmd_ready}, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule